// File: doc/BRIEF.md
# Serial Port Standby Wake Controller

This block sits next to a serial transmitter/receiver and decides what happens to the port when the system asks to sleep. It chooses between two things: keeping the port's core clock running, or stopping it once any transfer in flight has ended. It also decides which pending interrupt sources may raise a wake request. The decision depends on two inputs. One selects between an internally generated clock and an externally supplied serial clock. The other is a run-in-standby control bit. Together they give four policies.

The block holds the per-source interrupt flags and combines them onto one interrupt line. The flags clear while the port is disabled or held in software reset. Four control bits are written from the bus clock domain: software reset, port enable, receiver on and transmitter on. Each crosses into the core domain through its own toggle handshake, and each shows a busy flag until the core side has acknowledged it.

Top module: `sbw_standby_ctl`

## Requirements
- R1: A bus write with `ctl_mask` bit i set, while `sync_busy[i]` is low, captures `ctl_wdata[i]`. With both clocks shared, `sync_busy[i]` is high after the write edge, `ctl_core[i]` takes the new value 3 edges after it, and `sync_busy[i]` falls 5 edges after it. Bit positions are 0 software reset, 1 enable, 2 receiver on and 3 transmitter on.
- R2: A write to a control bit whose `sync_busy` bit is high is ignored, and the core copy keeps the earlier value.
- R3: With the internal clock (`clk_ext`=0) and `run_stby`=1, `core_clk_en` stays 1 through sleep.
- R4: While `xfer_busy` is high, entry to sleep waits and `core_clk_en` stays 1. The first edge that samples `xfer_busy` low with `sleep_req` high enters sleep. With `run_stby`=0, `core_clk_en` is 0 from that edge on.
- R5: `core_clk_en` returns to 1 in the same cycle that `sleep_req` falls, with no clock edge in between.
- R6: `rx_drop` is 1 only while asleep with `clk_ext`=1 and `run_stby`=0, and the core clock is disabled at that time.
- R7: With the internal clock and `run_stby`=1, any source whose flag and enable are both set raises `wake` while asleep.
- R8: With the external clock and `run_stby`=1, or with the internal clock and `run_stby`=0, only source 0 (receive complete) can raise `wake`.
- R9: With the external clock and `run_stby`=0, `wake` is never raised.
- R10: `wake` is 0 unless `sleep_req` is high and the block has left the awake state.
- R11: `irq` is the OR over all sources of flag AND enable, whether or not the block is asleep.
- R12: A pulse on `irq_set[i]` sets flag i and a pulse on `irq_clr[i]` clears it. Both take effect at the next edge, and a set wins over a clear in the same cycle.
- R13: All flags are 0 from the edge after the core copy shows enable=0 or software reset=1, and they stay 0 for as long as that holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus domain clock |
| bus_rst_n | input | 1 | Bus domain reset, active low |
| ctl_wr | input | 1 | Control write strobe |
| ctl_mask | input | 4 | Selects which control bits the write touches |
| ctl_wdata | input | 4 | Control write data |
| sync_busy | output | 4 | Per-bit crossing in progress |
| core_clk | input | 1 | Free-running core clock |
| core_rst_n | input | 1 | Core domain reset, active low |
| ctl_core | output | 4 | Control bits as seen in the core domain |
| sleep_req | input | 1 | System sleep request |
| run_stby | input | 1 | Keep running in standby |
| clk_ext | input | 1 | 1 = external serial clock, 0 = internal clock |
| xfer_busy | input | 1 | Transfer in progress |
| irq_set | input | 4 | Per-source flag set pulses |
| irq_clr | input | 4 | Per-source flag clear pulses |
| irq_en | input | 4 | Per-source interrupt enables |
| irq_pend | output | 4 | Pending flags |
| irq | output | 1 | Combined interrupt request |
| wake | output | 1 | Wake request |
| core_clk_en | output | 1 | Core clock enable |
| rx_drop | output | 1 | Received data is being discarded |

## Verification
The wake logic is swept over all four clock-source and standby combinations. In each one, every pattern of pending flags is crossed with every pattern of enables. The sweep shows whether the policy mask admits all sources, only receive complete, or none, and it confirms that the combined interrupt ignores the mask. The sleep entry is exercised with the busy input held high for several cycles and then released, which shows whether gating waits for the transfer to end. The exit is checked before any clock edge, to confirm it is immediate. The control bits are followed edge by edge through the crossing, with a second write issued while the bit is busy, to show that the late write is dropped.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
    typedef enum logic [1:0] {
        PS_AWAKE = 2'd0,
        PS_DRAIN = 2'd1,
        PS_SLEEP = 2'd2
    } pstate_e;

    localparam int CTL_W     = 4;
    localparam int CTL_SWRST = 0;
    localparam int CTL_ENA   = 1;
endpackage

// File: rtl/sbw_bit_sync.sv
module sbw_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic bus_clk,
    input  logic bus_rst_n,
    input  logic wr_stb,
    input  logic wr_val,
    output logic busy,
    input  logic core_clk,
    input  logic core_rst_n,
    output logic core_val
);
    typedef struct packed {
        logic              val;
        logic              req;
        logic [STAGES-1:0] ack_sh;
    } bus_st_t;

    typedef struct packed {
        logic [STAGES-1:0] req_sh;
        logic              ack;
        logic              val;
    } core_st_t;

    bus_st_t  bus_d, bus_q;
    core_st_t core_d, core_q;

    // bus side: capture and toggle request, bring acknowledge back
    always_comb begin
        bus_d = bus_q;
        bus_d.ack_sh = {bus_q.ack_sh[STAGES-2:0], core_q.ack};
        if (wr_stb && !busy) begin
            bus_d.val = wr_val;
            bus_d.req = ~bus_q.req;
        end
    end

    always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n) bus_q <= '0;
        else            bus_q <= bus_d;
    end

    assign busy = bus_q.req != bus_q.ack_sh[STAGES-1];

    // core side: detect toggle, take value, return acknowledge
    always_comb begin
        core_d = core_q;
        core_d.req_sh = {core_q.req_sh[STAGES-2:0], bus_q.req};
        if (core_q.req_sh[STAGES-1] != core_q.ack) begin
            core_d.val = bus_q.val;
            core_d.ack = core_q.req_sh[STAGES-1];
        end
    end

    always_ff @(posedge core_clk or negedge core_rst_n) begin
        if (!core_rst_n) core_q <= '0;
        else             core_q <= core_d;
    end

    assign core_val = core_q.val;

    p_accept_r1: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (wr_stb && !busy) |=> busy);
    p_busy_ignore_r2: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (wr_stb && busy) |=> $stable(bus_q.val));
    p_core_hold_r1: assert property (@(posedge core_clk) disable iff (!core_rst_n)
        (core_q.req_sh[STAGES-1] == core_q.ack) |=> $stable(core_val));
endmodule

// File: rtl/sbw_sleep_gate.sv
module sbw_sleep_gate
    import sbw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic xfer_busy,
    input  logic run_stby,
    input  logic clk_ext,
    output logic core_clk_en,
    output logic rx_drop,
    output logic sleep_act
);
    typedef struct packed {
        pstate_e st;
    } gate_st_t;

    gate_st_t gate_d, gate_q;

    always_comb begin
        gate_d = gate_q;
        if (!sleep_req) begin
            gate_d.st = PS_AWAKE;
        end else begin
            case (gate_q.st)
                PS_AWAKE: gate_d.st = xfer_busy ? PS_DRAIN : PS_SLEEP;
                PS_DRAIN: if (!xfer_busy) gate_d.st = PS_SLEEP;
                PS_SLEEP: gate_d.st = PS_SLEEP;
                default:  gate_d.st = PS_AWAKE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= '{st: PS_AWAKE};
        else        gate_q <= gate_d;
    end

    logic gated;
    assign gated       = sleep_req && (gate_q.st == PS_SLEEP);
    assign core_clk_en = !(gated && !run_stby);
    assign rx_drop     = gated && clk_ext && !run_stby;
    assign sleep_act   = sleep_req && (gate_q.st != PS_AWAKE);

    p_hold_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && xfer_busy && gate_q.st != PS_SLEEP) |=> core_clk_en);
    p_leave_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_req |-> core_clk_en);
endmodule

// File: rtl/sbw_irq_wake.sv
module sbw_irq_wake #(
    parameter int N       = 4,
    parameter int RXC_IDX = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_all,
    input  logic [N-1:0] irq_set,
    input  logic [N-1:0] irq_clr,
    input  logic [N-1:0] irq_en,
    input  logic         run_stby,
    input  logic         clk_ext,
    input  logic         sleep_act,
    output logic [N-1:0] irq_pend,
    output logic         irq,
    output logic         wake
);
    typedef struct packed {
        logic [N-1:0] pend;
    } flag_st_t;

    flag_st_t flg_d, flg_q;
    logic [N-1:0] pol_mask;
    logic [N-1:0] active;

    always_comb begin
        flg_d = flg_q;
        if (clr_all) flg_d.pend = '0;
        else         flg_d.pend = (flg_q.pend & ~irq_clr) | irq_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    // per-source policy: all sources, receive-complete only, or none
    for (genvar i = 0; i < N; i++) begin : g_src
        if (i == RXC_IDX) begin : g_rxc
            assign pol_mask[i] = !(clk_ext && !run_stby);
        end else begin : g_other
            assign pol_mask[i] = !clk_ext && run_stby;
        end
    end

    assign active   = flg_q.pend & irq_en;
    assign irq_pend = flg_q.pend;
    assign irq      = |active;
    assign wake     = sleep_act && |(active & pol_mask);

    p_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (irq_pend == '0));
    p_rxc_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && (clk_ext == run_stby)) |-> (irq_pend[RXC_IDX] && irq_en[RXC_IDX]));
    p_wake_needs_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> irq);
endmodule

// File: rtl/sbw_standby_ctl.sv
module sbw_standby_ctl
    import sbw_pkg::*;
#(
    parameter int N_IRQ       = 4,
    parameter int RXC_IDX     = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic             bus_clk,
    input  logic             bus_rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_mask,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] sync_busy,
    input  logic             core_clk,
    input  logic             core_rst_n,
    output logic [CTL_W-1:0] ctl_core,
    input  logic             sleep_req,
    input  logic             run_stby,
    input  logic             clk_ext,
    input  logic             xfer_busy,
    input  logic [N_IRQ-1:0] irq_set,
    input  logic [N_IRQ-1:0] irq_clr,
    input  logic [N_IRQ-1:0] irq_en,
    output logic [N_IRQ-1:0] irq_pend,
    output logic             irq,
    output logic             wake,
    output logic             core_clk_en,
    output logic             rx_drop
);
    for (genvar b = 0; b < CTL_W; b++) begin : g_ctl
        sbw_bit_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .bus_clk    (bus_clk),
            .bus_rst_n  (bus_rst_n),
            .wr_stb     (ctl_wr && ctl_mask[b]),
            .wr_val     (ctl_wdata[b]),
            .busy       (sync_busy[b]),
            .core_clk   (core_clk),
            .core_rst_n (core_rst_n),
            .core_val   (ctl_core[b])
        );
    end

    logic sleep_act;
    logic flags_clr;

    assign flags_clr = !ctl_core[CTL_ENA] || ctl_core[CTL_SWRST];

    sbw_sleep_gate u_gate (
        .clk         (core_clk),
        .rst_n       (core_rst_n),
        .sleep_req   (sleep_req),
        .xfer_busy   (xfer_busy),
        .run_stby    (run_stby),
        .clk_ext     (clk_ext),
        .core_clk_en (core_clk_en),
        .rx_drop     (rx_drop),
        .sleep_act   (sleep_act)
    );

    sbw_irq_wake #(.N(N_IRQ), .RXC_IDX(RXC_IDX)) u_irq (
        .clk       (core_clk),
        .rst_n     (core_rst_n),
        .clr_all   (flags_clr),
        .irq_set   (irq_set),
        .irq_clr   (irq_clr),
        .irq_en    (irq_en),
        .run_stby  (run_stby),
        .clk_ext   (clk_ext),
        .sleep_act (sleep_act),
        .irq_pend  (irq_pend),
        .irq       (irq),
        .wake      (wake)
    );

    p_wake_sleep_r10: assert property (@(posedge core_clk) disable iff (!core_rst_n)
        wake |-> sleep_req);
    p_drop_gate_r6: assert property (@(posedge core_clk) disable iff (!core_rst_n)
        rx_drop |-> (clk_ext && !run_stby && !core_clk_en));
    p_no_wake_r9: assert property (@(posedge core_clk) disable iff (!core_rst_n)
        (clk_ext && !run_stby) |-> !wake);
    p_stby_on_r3: assert property (@(posedge core_clk) disable iff (!core_rst_n)
        (!clk_ext && run_stby) |-> core_clk_en);
endmodule

// File: tb/tb_sbw_standby_ctl.sv
module tb_sbw_standby_ctl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       ctl_wr;
    logic [3:0] ctl_mask, ctl_wdata, sync_busy, ctl_core;
    logic       sleep_req, run_stby, clk_ext, xfer_busy;
    logic [3:0] irq_set, irq_clr, irq_en, irq_pend;
    logic       irq, wake, core_clk_en, rx_drop;
    int         total = 0;
    int         bad = 0;

    always #5 clk = ~clk;

    sbw_standby_ctl dut (
        .bus_clk(clk), .bus_rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_mask(ctl_mask),
        .ctl_wdata(ctl_wdata), .sync_busy(sync_busy), .core_clk(clk),
        .core_rst_n(rst_n), .ctl_core(ctl_core), .sleep_req(sleep_req),
        .run_stby(run_stby), .clk_ext(clk_ext), .xfer_busy(xfer_busy),
        .irq_set(irq_set), .irq_clr(irq_clr), .irq_en(irq_en),
        .irq_pend(irq_pend), .irq(irq), .wake(wake),
        .core_clk_en(core_clk_en), .rx_drop(rx_drop)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [3:0] mask_of(input logic ext, input logic stby);
        if (!ext && stby)      return 4'b1111;
        else if (ext && !stby) return 4'b0000;
        else                   return 4'b0001;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ctl_wr = 0; ctl_mask = 0; ctl_wdata = 0;
        sleep_req = 0; run_stby = 0; clk_ext = 0; xfer_busy = 0;
        irq_set = 0; irq_clr = 0; irq_en = 0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 reset ctl_core", 32'(ctl_core), 32'h0);
        chk("R1 reset busy", 32'(sync_busy), 32'h0);
        chk("R13 reset pend", 32'(irq_pend), 32'h0);
        chk("R5 reset clk_en", 32'(core_clk_en), 32'h1);
        chk("R10 reset wake", 32'(wake), 32'h0);
        chk("R6 reset rx_drop", 32'(rx_drop), 32'h0);

        // R13: port disabled, flags cannot set
        irq_set = 4'hF; tick(); irq_set = 0;
        chk("R13 disabled set ignored", 32'(irq_pend), 32'h0);

        // R1 / R2: enable bit crossing, second write while busy
        ctl_wr = 1; ctl_mask = 4'b0010; ctl_wdata = 4'b0010;
        tick();
        ctl_wdata = 4'b0000;
        chk("R1 busy after write", 32'(sync_busy), 32'h2);
        chk("R1 core k+0", 32'(ctl_core), 32'h0);
        tick();
        ctl_wr = 0;
        chk("R1 core k+1", 32'(ctl_core), 32'h0);
        tick(); chk("R1 core k+2", 32'(ctl_core), 32'h0);
        tick(); chk("R1 core k+3", 32'(ctl_core), 32'h2);
        tick(); chk("R1 busy k+4", 32'(sync_busy), 32'h2);
        tick(); chk("R1 busy k+5", 32'(sync_busy), 32'h0);
        repeat (4) tick();
        chk("R2 busy write ignored", 32'(ctl_core), 32'h2);

        // R1: two bits at once
        ctl_wr = 1; ctl_mask = 4'b1100; ctl_wdata = 4'b1100;
        tick(); ctl_wr = 0;
        chk("R1 two busy", 32'(sync_busy), 32'hC);
        repeat (5) tick();
        chk("R1 two core", 32'(ctl_core), 32'hE);
        chk("R1 two idle", 32'(sync_busy), 32'h0);

        // R12 flag set/clear
        irq_set = 4'b0011; tick();
        chk("R12 set", 32'(irq_pend), 32'h3);
        irq_set = 4'b0100; irq_clr = 4'b0001; tick();
        chk("R12 set and clear", 32'(irq_pend), 32'h6);
        irq_set = 4'b0010; irq_clr = 4'b0010; tick();
        chk("R12 set wins", 32'(irq_pend), 32'h6);
        irq_set = 0; irq_clr = 4'hF; tick(); irq_clr = 0;
        chk("R12 clear all", 32'(irq_pend), 32'h0);

        // R11 / R10 while awake
        irq_set = 4'b0101; irq_en = 4'b0100; tick(); irq_set = 0;
        chk("R11 awake irq", 32'(irq), 32'h1);
        chk("R10 awake no wake", 32'(wake), 32'h0);
        irq_en = 4'b1010; #1;
        chk("R11 disabled irq", 32'(irq), 32'h0);

        // sweep over modes, flags and enables
        sleep_req = 1; xfer_busy = 0;
        for (int m = 0; m < 4; m++) begin
            clk_ext = m[1]; run_stby = m[0];
            tick();
            for (int p = 0; p < 16; p++) begin
                for (int e = 0; e < 16; e++) begin
                    irq_en = 4'(e); irq_set = 4'(p); irq_clr = 4'hF;
                    tick();
                    chk("R12 sweep pend", 32'(irq_pend), 32'(p));
                    chk("R11 sweep irq", 32'(irq), 32'(|(4'(p) & 4'(e))));
                    chk(m == 1 ? "R7 sweep wake" : (m == 2 ? "R9 sweep wake" : "R8 sweep wake"),
                        32'(wake), 32'(|(4'(p) & 4'(e) & mask_of(m[1], m[0]))));
                end
            end
            chk(m == 1 ? "R3 sweep clk_en" : "R4 sweep clk_en", 32'(core_clk_en), 32'(m[0]));
            chk("R6 sweep rx_drop", 32'(rx_drop), 32'(m == 2));
        end
        irq_set = 0; irq_clr = 4'hF; tick(); irq_clr = 0;

        // R4 drain wait, R5 immediate exit
        sleep_req = 0; tick();
        clk_ext = 0; run_stby = 0; xfer_busy = 1; sleep_req = 1;
        tick(); chk("R4 drain clk_en", 32'(core_clk_en), 32'h1);
        tick(); chk("R4 drain clk_en 2", 32'(core_clk_en), 32'h1);
        tick(); chk("R4 drain clk_en 3", 32'(core_clk_en), 32'h1);
        xfer_busy = 0; #1;
        chk("R4 before edge", 32'(core_clk_en), 32'h1);
        tick(); chk("R4 gated", 32'(core_clk_en), 32'h0);
        chk("R6 internal no drop", 32'(rx_drop), 32'h0);
        sleep_req = 0; #1;
        chk("R5 immediate exit", 32'(core_clk_en), 32'h1);
        tick(); chk("R5 awake", 32'(core_clk_en), 32'h1);

        // R6 external without standby
        clk_ext = 1; run_stby = 0; sleep_req = 1;
        tick();
        chk("R6 drop", 32'(rx_drop), 32'h1);
        chk("R6 clock off", 32'(core_clk_en), 32'h0);
        sleep_req = 0; #1;
        chk("R6 drop ends", 32'(rx_drop), 32'h0);
        tick();

        // R13 software reset clears flags
        irq_set = 4'hF; tick(); irq_set = 0;
        chk("R13 pre swrst", 32'(irq_pend), 32'hF);
        ctl_wr = 1; ctl_mask = 4'b0001; ctl_wdata = 4'b0001;
        tick(); ctl_wr = 0;
        repeat (5) tick();
        chk("R13 swrst clears", 32'(irq_pend), 32'h0);
        irq_set = 4'hF; tick(); irq_set = 0;
        chk("R13 swrst holds", 32'(irq_pend), 32'h0);
        ctl_wr = 1; ctl_mask = 4'b0001; ctl_wdata = 4'b0000;
        tick(); ctl_wr = 0;
        repeat (5) tick();
        irq_set = 4'b0001; tick(); irq_set = 0;
        chk("R13 released", 32'(irq_pend), 32'h1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule